// File: doc/BRIEF.md
# Dual-Compare PWM Timer

This block is a 16-bit timer with two compare channels that can run in three ways. In free-running mode the counter wraps through its whole range. A match on either compare value raises that channel's flag and drives the output pin to that channel's level bit. In pulse-width-modulation mode a match on the first compare drives the pin to the first level. A match on the second compare drives the pin to the second level and reloads the counter with 16'hFFFC, so the second compare sets the period. In single-pulse mode a rising edge on capture input 1 reloads the counter and drives the first level. The next first-compare match then drives the second level.

The counter advances on a tick. The tick comes either from a divide-by-2, 4 or 8 prescaler on the system clock, or from the rising edge of an external timer clock after synchronisation. Software loads each compare value a byte at a time. A write to the high byte disarms that channel until its low byte is written. The reload value starts four counts below zero, so a PWM period is the second compare value plus 5 ticks. Four flags are cleared by a write-one strobe, and one interrupt line combines them.

Top module: `pwm_cmp_timer`

## Requirements
- R1: After reset the counter holds 16'hFFFC, the pin is 0, all four flags are 0 and both compare channels are disarmed.
- R2: `ck_sel` 2'b00, 2'b01 and 2'b10 give one tick every 2, 4 and 8 system clocks. 2'b11 gives one tick per rising edge of `ext_clk`, seen through a two-flop synchroniser. The counter does not move without a tick.
- R3: In PWM mode, a tick that leaves the count equal to compare 1 drives the pin to `lvl1`. A tick that leaves compare 2 drives the pin to `lvl2` and reloads 16'hFFFC. The period is (cmp2+5) ticks, and with `lvl1`=1 and `lvl2`=0 the high time is (cmp2−cmp1) ticks.
- R4: In PWM mode with `lvl1` equal to `lvl2`, the pin settles at that level and stays constant.
- R5: Each channel has a write select: `wr_sel` 0 is compare-1 high byte, 1 is compare-1 low byte, 2 is compare-2 high byte and 3 is compare-2 low byte. A high-byte write disarms the channel and a low-byte write arms it. A disarmed channel produces no match.
- R6: In PWM mode `ocf1` and `ocf2` are never set. `icf1` is set at every period end, that is on a compare-2 match.
- R7: `irq` = ((`ocf1`|`ocf2`)&`ocie` | (`icf1`|`icf2`)&`icie`) & !`gmask`.
- R8: In PWM mode capture input 1 has no effect on the counter or the pin. A rising edge on capture input 2 sets `icf2` and loads `cap2` with the count.
- R9: When `pwm_en` and `opm_en` are both 1, the block behaves exactly as in PWM mode.
- R10: In free-running mode a match on compare n sets `ocf`n and drives the pin to `lvl`n, and the counter keeps counting without a reload.
- R11: In single-pulse mode (`opm_en`=1, `pwm_en`=0), a rising edge on capture input 1 reloads 16'hFFFC and drives the pin to `lvl1`. The next compare-1 match drives the pin to `lvl2`, so the pulse lasts (cmp1+5) ticks.
- R12: `clr_flags` bits 0 to 3 clear `ocf1`, `ocf2`, `icf1` and `icf2` in that order. A set in the same cycle wins over a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ck_sel | input | 2 | Tick source select |
| ext_clk | input | 1 | External timer clock |
| pwm_en | input | 1 | PWM mode enable |
| opm_en | input | 1 | Single-pulse mode enable |
| lvl1 | input | 1 | Pin level on compare-1 match |
| lvl2 | input | 1 | Pin level on compare-2 match |
| ocie | input | 1 | Compare interrupt enable |
| icie | input | 1 | Capture interrupt enable |
| gmask | input | 1 | Global interrupt mask, 1 blocks `irq` |
| wr_en | input | 1 | Compare byte write strobe |
| wr_sel | input | 2 | Compare byte select |
| wr_data | input | 8 | Compare byte data |
| clr_flags | input | 4 | Write-one flag clear |
| icap1 | input | 1 | Capture input 1 |
| icap2 | input | 1 | Capture input 2 |
| ocmp | output | 1 | Compare output pin |
| cnt | output | 16 | Counter value |
| cap2 | output | 16 | Capture-2 register |
| ocf1 | output | 1 | Compare-1 flag |
| ocf2 | output | 1 | Compare-2 flag |
| icf1 | output | 1 | Capture-1 / period-end flag |
| icf2 | output | 1 | Capture-2 flag |
| irq | output | 1 | Interrupt request |

## Verification
The hardest thing to set up is the start of a PWM run. The compare values must be armed before the counter, which starts a few ticks below zero, passes them. Otherwise the next match is a full 65536-tick wrap away. The stimulus first selects the external clock and holds it low, which freezes the counter at its reload value, and only then writes all four bytes. It then releases the tick source and measures exact high and period lengths in system clocks. Capture pulses are driven in a parallel thread during a measurement, which shows that capture 1 leaves the waveform unchanged.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;
  typedef enum logic [1:0] {
    CK_DIV2 = 2'b00,
    CK_DIV4 = 2'b01,
    CK_DIV8 = 2'b10,
    CK_EXT  = 2'b11
  } ck_sel_e;
  localparam int CNT_W = 16;
  localparam int NCH = 2;
  localparam int NFLAG = 4;
endpackage

// File: rtl/pwmt_edge_sync.sv
module pwmt_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], din};
  end

  assign rise = sh[STAGES-1] & ~sh[STAGES];

  assert_rise_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/pwmt_tick_gen.sv
module pwmt_tick_gen
  import pwmt_pkg::*;
#(
  parameter int DIV_W = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] ck_sel,
  input  logic       ext_rise,
  output logic       tick
);
  logic [DIV_W-1:0] pc;
  logic [DIV_W-1:0] mask;

  always_ff @(posedge clk) begin
    if (!rst_n) pc <= '0;
    else        pc <= pc + 1'b1;
  end

  always_comb begin
    mask = '0;
    unique case (ck_sel_e'(ck_sel))
      CK_DIV2: mask = DIV_W'(1);
      CK_DIV4: mask = DIV_W'(3);
      CK_DIV8: mask = DIV_W'(7);
      default: mask = '0;
    endcase
  end

  assign tick = (ck_sel == CK_EXT) ? ext_rise : ((pc & mask) == mask);

  assert_tick_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && $stable(ck_sel)) |=> !tick);
endmodule

// File: rtl/pwmt_cmp_chan.sv
module pwmt_cmp_chan #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_hi,
  input  logic         wr_lo,
  input  logic [7:0]   wr_byte,
  output logic [W-1:0] val,
  output logic         armed
);
  localparam int HB = W - 8;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      val   <= '0;
      armed <= 1'b0;
    end else if (wr_hi) begin
      val[W-1:8] <= wr_byte[HB-1:0];
      armed      <= 1'b0;
    end else if (wr_lo) begin
      val[7:0] <= wr_byte;
      armed    <= 1'b1;
    end
  end

  assert_hi_disarms_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |=> !armed);
  assert_lo_arms_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && !wr_hi) |=> armed);
endmodule

// File: rtl/pwm_cmp_timer.sv
module pwm_cmp_timer
  import pwmt_pkg::*;
#(
  parameter int          W      = CNT_W,
  parameter logic [15:0] RELOAD = 16'hFFFC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   ck_sel,
  input  logic         ext_clk,
  input  logic         pwm_en,
  input  logic         opm_en,
  input  logic         lvl1,
  input  logic         lvl2,
  input  logic         ocie,
  input  logic         icie,
  input  logic         gmask,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [7:0]   wr_data,
  input  logic [3:0]   clr_flags,
  input  logic         icap1,
  input  logic         icap2,
  output logic         ocmp,
  output logic [W-1:0] cnt,
  output logic [W-1:0] cap2,
  output logic         ocf1,
  output logic         ocf2,
  output logic         icf1,
  output logic         icf2,
  output logic         irq
);
  localparam int NSYNC = 3;

  logic [NSYNC-1:0] raw_in, rise;
  logic             tick;
  logic [W-1:0]     cval [NCH];
  logic [NCH-1:0]   armed, match;
  logic             pwm_act, opm_act, opm_trig, reload;
  logic [NFLAG-1:0] flags, fset;

  assign raw_in = {icap2, icap1, ext_clk};

  for (genvar s = 0; s < NSYNC; s++) begin : g_sync
    pwmt_edge_sync #(.STAGES(2)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(raw_in[s]), .rise(rise[s]));
  end

  pwmt_tick_gen #(.DIV_W(3)) u_tick (
    .clk(clk), .rst_n(rst_n), .ck_sel(ck_sel), .ext_rise(rise[0]), .tick(tick));

  for (genvar c = 0; c < NCH; c++) begin : g_cmp
    pwmt_cmp_chan #(.W(W)) u_chan (
      .clk(clk), .rst_n(rst_n),
      .wr_hi(wr_en && (wr_sel == 2'(2*c))),
      .wr_lo(wr_en && (wr_sel == 2'(2*c+1))),
      .wr_byte(wr_data), .val(cval[c]), .armed(armed[c]));
    assign match[c] = tick && armed[c] && (cnt == cval[c]);
  end

  // PWM takes priority over single-pulse mode
  assign pwm_act  = pwm_en;
  assign opm_act  = opm_en & ~pwm_en;
  assign opm_trig = opm_act & rise[1];
  assign reload   = opm_trig | (pwm_act & match[1]);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= RELOAD;
    else if (reload) cnt <= RELOAD;
    else if (tick)   cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ocmp <= 1'b0;
    else if (opm_trig) ocmp <= lvl1;
    else if (opm_act) begin
      if (match[0]) ocmp <= lvl2;
    end else begin
      if (match[1])      ocmp <= lvl2;
      else if (match[0]) ocmp <= lvl1;
    end
  end

  assign fset[0] = ~pwm_act & match[0];
  assign fset[1] = ~pwm_act & match[1];
  assign fset[2] = pwm_act ? match[1] : rise[1];
  assign fset[3] = rise[2];

  always_ff @(posedge clk) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clr_flags) | fset;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       cap2 <= '0;
    else if (rise[2]) cap2 <= cnt;
  end

  assign {icf2, icf1, ocf2, ocf1} = flags;
  assign irq = (((ocf1 | ocf2) & ocie) | ((icf1 | icf2) & icie)) & ~gmask;

  assert_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_en && tick && armed[1] && cnt == cval[1]) |=> (cnt == RELOAD));
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !opm_trig) |=> $stable(cnt));
  assert_no_ocf_pwm_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_en |=> (!$rose(ocf1) && !$rose(ocf2)));
  assert_period_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_en && tick && armed[1] && cnt == cval[1]) |=> icf1);
  assert_irq_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
    gmask |-> !irq);
  assert_pwm_pin_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_en && tick && armed[1] && cnt == cval[1]) |=> (ocmp == $past(lvl2)));
endmodule

// File: tb/sim_pwm_cmp_timer.sv
module sim_pwm_cmp_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] ck_sel = 2'b11;
  logic ext_clk = 1'b0, pwm_en = 1'b0, opm_en = 1'b0, lvl1 = 1'b0, lvl2 = 1'b0;
  logic ocie = 1'b0, icie = 1'b0, gmask = 1'b0, wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic [3:0] clr_flags = '0;
  logic icap1 = 1'b0, icap2 = 1'b0;
  logic ocmp, ocf1, ocf2, icf1, icf2, irq;
  logic [15:0] cnt, cap2;
  int total = 0, bad = 0;
  bit done = 0;
  bit ext_run = 0;

  always #4 clk = ~clk;

  pwm_cmp_timer u0 (.*);

  always begin
    @(posedge clk);
    if (ext_run) begin
      repeat (2) @(posedge clk);
      ext_clk <= ~ext_clk;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    pwm_en = 0; opm_en = 0; ck_sel = 2'b11; ext_run = 0; ext_clk = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    wr_en = 1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic set_cmp(input int ch, input logic [15:0] v);
    wr(2'(2*ch), v[15:8]);
    wr(2'(2*ch+1), v[7:0]);
  endtask

  task automatic clr(input logic [3:0] m);
    clr_flags = m;
    @(negedge clk);
    clr_flags = 0;
  endtask

  // measure one full high phase and one full period, in system clocks
  task automatic measure(output int hi, output int per);
    int n = 0;
    logic prev;
    hi = 0; per = 0;
    prev = ocmp;
    while (!(ocmp && !prev) && n < 5000) begin
      prev = ocmp; @(negedge clk); n++;
    end
    while (ocmp && n < 5000) begin
      @(negedge clk); hi++; per++; n++;
    end
    while (!ocmp && n < 5000) begin
      @(negedge clk); per++; n++;
    end
  endtask

  task automatic t_reset();
    do_reset();
    chk(cnt == 16'hFFFC, "R1 count", cnt, 16'hFFFC);
    chk(ocmp == 0, "R1 pin", ocmp, 0);
    chk({ocf1, ocf2, icf1, icf2} == 0, "R1 flags", {ocf1, ocf2, icf1, icf2}, 0);
    repeat (10) @(negedge clk);
    chk(cnt == 16'hFFFC, "R2 frozen without ext edge", cnt, 16'hFFFC);
  endtask

  task automatic t_free();
    do_reset();
    lvl1 = 0; lvl2 = 1;
    wr(2'd0, 8'h00);
    set_cmp(1, 16'h0005);
    ck_sel = 2'b00;
    repeat (40) @(negedge clk);
    chk(ocf1 == 0, "R5 half-written channel silent", ocf1, 0);
    chk(ocf2 == 1, "R10 compare-2 flag", ocf2, 1);
    chk(ocmp == 1, "R10 pin takes lvl2", ocmp, 1);
    chk(cnt > 16'h0006 && cnt < 16'h0030, "R10 no reload", cnt, 16'h0010);
    wr(2'd1, 8'h30);
    repeat (100) @(negedge clk);
    chk(ocf1 == 1, "R5 armed by low byte", ocf1, 1);
    chk(ocmp == 0, "R10 pin takes lvl1", ocmp, 0);
    ocie = 1; gmask = 0; @(negedge clk);
    chk(irq == 1, "R7 irq on flag", irq, 1);
    gmask = 1; @(negedge clk);
    chk(irq == 0, "R7 mask blocks irq", irq, 0);
    gmask = 0; ocie = 0; @(negedge clk);
    chk(irq == 0, "R7 enable off", irq, 0);
    clr(4'b0001);
    chk(ocf1 == 0 && ocf2 == 1, "R12 clear only bit 0", {ocf1, ocf2}, 1);
  endtask

  task automatic t_pwm(input logic [1:0] sel, input int div, input bit both);
    int hi, per;
    do_reset();
    lvl1 = 1; lvl2 = 0;
    set_cmp(0, 16'd2);
    set_cmp(1, 16'd6);
    pwm_en = 1; opm_en = both; ck_sel = sel;
    if (sel == 2'b11) ext_run = 1;
    if (both) begin
      fork
        measure(hi, per);
        repeat (6) begin
          icap1 = 1; repeat (4) @(negedge clk);
          icap1 = 0; repeat (5) @(negedge clk);
        end
      join
    end else begin
      measure(hi, per);
    end
    chk(hi == 4 * div, both ? "R9 high time" : "R3 high time", hi, 4 * div);
    chk(per == 11 * div, both ? "R8 R9 period unchanged" : "R3 period", per, 11 * div);
    chk(ocf1 == 0 && ocf2 == 0, "R6 no compare flags", {ocf1, ocf2}, 0);
    chk(icf1 == 1, "R6 period-end flag", icf1, 1);
    icie = 1; @(negedge clk);
    chk(irq == 1, "R7 capture irq", irq, 1);
    icie = 0;
    if (sel == 2'b11) begin
      logic [15:0] c0;
      ext_run = 0;
      repeat (6) @(negedge clk);
      c0 = cnt;
      repeat (20) @(negedge clk);
      chk(cnt == c0, "R2 ext stopped holds count", cnt, c0);
    end
  endtask

  task automatic t_cap2();
    do_reset();
    set_cmp(1, 16'd6);
    pwm_en = 1; ck_sel = 2'b00;
    repeat (30) @(negedge clk);
    icap2 = 1; repeat (4) @(negedge clk); icap2 = 0;
    repeat (2) @(negedge clk);
    chk(icf2 == 1, "R8 capture-2 flag", icf2, 1);
    chk(cap2 >= 16'hFFFC || cap2 <= 16'd6, "R8 capture-2 value in period", cap2, 0);
    clr(4'b1000);
    chk(icf2 == 0, "R12 clear capture-2 flag", icf2, 0);
  endtask

  task automatic t_const();
    bit steady = 1;
    do_reset();
    lvl1 = 1; lvl2 = 1;
    set_cmp(0, 16'd2);
    set_cmp(1, 16'd6);
    pwm_en = 1; ck_sel = 2'b00;
    repeat (30) @(negedge clk);
    for (int i = 0; i < 60; i++) begin
      if (ocmp != 1) steady = 0;
      @(negedge clk);
    end
    chk(steady, "R4 constant level", steady, 1);
  endtask

  task automatic t_opm();
    int w = 0;
    do_reset();
    lvl1 = 1; lvl2 = 0;
    set_cmp(0, 16'h0010);
    opm_en = 1; ck_sel = 2'b00;
    repeat (60) @(negedge clk);
    chk(ocmp == 0, "R11 idle before trigger", ocmp, 0);
    icap1 = 1;
    while (!ocmp && w < 20) begin @(negedge clk); w++; end
    icap1 = 0;
    chk(cnt >= 16'hFFFC || cnt <= 16'd1, "R11 reload on trigger", cnt, 16'hFFFC);
    w = 0;
    while (ocmp && w < 500) begin @(negedge clk); w++; end
    chk(w >= 41 && w <= 42, "R11 pulse width", w, 42);
  endtask

  initial begin
    t_reset();
    t_free();
    t_pwm(2'b00, 2, 0);
    t_pwm(2'b00, 2, 1);
    t_pwm(2'b10, 8, 0);
    t_pwm(2'b11, 6, 0);
    t_cap2();
    t_const();
    t_opm();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule